// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block turns the attributes of an external bus cycle into active-low select strobes for memories and peripherals. It watches the cycle's address, address-space code, direction, active byte lanes and, for interrupt acknowledge cycles, the priority level. Each channel holds a base address, a block size, an option word and a pin mode. When every attribute agrees with a channel's settings, that channel drives its pin low in the clock after the chosen strobe qualifies. The same channel can also end the cycle itself after a programmed number of wait states.

Channels are configured through simple single-cycle writes. A channel's pin can instead carry a discrete output level or an alternate function signal. Channel 0 is the boot channel. It is live out of reset and covers the bottom of the address space. Its port width is taken from a data line sampled during reset. All other channels come out of reset unable to assert.

Top module: `chipsel_decoder`

## Requirements
- R1: A channel matches an address only when the address bits at and above position 11+K equal its base, where K is the 3-bit block code (block size 2 KB << K). Base word: bits [15:3] hold address bits [23:11] and bits [2:0] hold K.
- R2: The option space field (bits [10:9]) decides which cycles a channel accepts. The cycle space input uses 00 for CPU space, 01 for user and 10 for supervisor. Field 00 accepts CPU space only, 01 user only, 10 supervisor only and 11 either user or supervisor. With field 00 the level field (bits [13:11]) must be 0, which accepts any level, or must equal the cycle's level.
- R3: The direction field (bits [3:2]) accepts reads when bit 2 is set and writes when bit 3 is set. Value 00 never matches.
- R4: The lane field (bits [1:0]: bit 0 lower, bit 1 upper) must share at least one set bit with the cycle's active lanes. After reset every channel except channel 0 has lane field 00 and never asserts.
- R5: A cycle flagged as served by an internal target asserts no select, whatever else matches.
- R6: The strobe bit (option bit 4) times the select with the address strobe (0) or the data strobe (1). The pin goes low in the clock after the strobe and the match are both present, and goes high in the clock after either is removed.
- R7: The termination field (bits [8:5]) sets the internal acknowledge. A value n from 0 to 13 raises the acknowledge n+1 clocks after the select first shows. Value 14 raises it in the same clock as the select. Value 15 never raises it. The acknowledge stays up while the select stays.
- R8: When several channels are selected at once, the lowest-numbered one alone decides the acknowledge. The width output reports that channel's port width.
- R9: Pin mode (pin word bits [1:0]): 00 drives the discrete bit (pin word bit 2), 01 passes the alternate input, 10 selects with an 8-bit port and 11 selects with a 16-bit port. A pin that is not in a select mode never shows a select.
- R10: Out of reset, channel 0 covers base 0 with block code 7, both lanes, both directions, user and supervisor space, address strobe timing and 13 wait states. Its port is 16 bits wide if the boot data line is high during reset and 8 bits wide if it is low. Other channels reset to 16-bit select mode, showing high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_d0 | input | 1 | Boot width strap, sampled while rst is high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_reg | input | 2 | 0 base word, 1 option word, 2 pin word |
| cfg_wdata | input | CFG_W | Write data |
| bus_as | input | 1 | Address strobe of the current cycle |
| bus_ds | input | 1 | Data strobe of the current cycle |
| bus_addr | input | ADDR_W | Cycle address |
| bus_space | input | 2 | Space code: 00 CPU, 01 user, 10 supervisor |
| bus_read | input | 1 | 1 for a read, 0 for a write |
| bus_lanes | input | 2 | Active byte lanes, bit 0 lower, bit 1 upper |
| bus_ipl | input | 3 | Priority level of an acknowledge cycle |
| bus_internal | input | 1 | Cycle is served by an on-chip target |
| alt_in | input | NUM_CH | Alternate function level for each pin |
| pin_out | output | NUM_CH | Pin levels; active-low when in select mode |
| int_ack | output | 1 | Internal cycle termination |
| ack_wide | output | 1 | Acknowledged port is 16 bits wide |

## Verification
The hardest case to reach is two channels selected by the same cycle but set to different terminations. The acknowledge must then follow the lower channel, even when that channel waits or leaves termination to external hardware while the higher one would end the cycle at once. The stimulus programs overlapping windows of different sizes. It then runs cycles inside both windows and inside only the larger one, and finally switches the lower channel to external termination. Cycles timed by the data strobe raise that strobe one clock after the address strobe, so a missing or early data strobe is exercised as well.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int BLK_CODE_W = 3;
    localparam int TERM_W     = 4;

    localparam logic [TERM_W-1:0] TERM_MAX_WAIT = 4'd13;
    localparam logic [TERM_W-1:0] TERM_FAST     = 4'd14;
    localparam logic [TERM_W-1:0] TERM_EXTERNAL = 4'd15;

    // option word layout, MSB first
    typedef struct packed {
        logic [2:0]        level;
        logic [1:0]        space;
        logic [TERM_W-1:0] term;
        logic              on_ds;
        logic [1:0]        dir;
        logic [1:0]        lanes;
    } opt_t;

    localparam int OPT_W = $bits(opt_t);

    typedef enum logic [1:0] {
        PIN_DISCRETE  = 2'b00,
        PIN_ALTERNATE = 2'b01,
        PIN_CS_NARROW = 2'b10,
        PIN_CS_WIDE   = 2'b11
    } pin_mode_e;

    localparam opt_t BOOT_OPT = '{level: 3'd0, space: 2'b11, term: 4'd13,
                                  on_ds: 1'b0, dir: 2'b11, lanes: 2'b11};

    function automatic logic space_ok(input logic [1:0] fld, input logic [1:0] cyc);
        case (fld)
            2'b00:   return cyc == 2'b00;
            2'b01:   return cyc == 2'b01;
            2'b10:   return cyc == 2'b10;
            default: return (cyc == 2'b01) || (cyc == 2'b10);
        endcase
    endfunction

    function automatic logic level_ok(input logic [1:0] fld, input logic [2:0] want,
                                      input logic [2:0] got);
        return (fld != 2'b00) || (want == 3'd0) || (want == got);
    endfunction

    function automatic logic dir_ok(input logic [1:0] fld, input logic rd);
        return rd ? fld[0] : fld[1];
    endfunction

endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
    import csd_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2,
    parameter int BASE_W = 13,
    parameter int CFG_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  boot_d0,
    input  logic                  cfg_we,
    input  logic [CH_W-1:0]       cfg_ch,
    input  logic [1:0]            cfg_reg,
    input  logic [CFG_W-1:0]      cfg_wdata,
    output logic [BASE_W-1:0]     base_o [NUM_CH],
    output logic [BLK_CODE_W-1:0] blk_o  [NUM_CH],
    output opt_t                  opt_o  [NUM_CH],
    output pin_mode_e             pin_o  [NUM_CH],
    output logic [NUM_CH-1:0]     disc_o
);

    localparam int BASE_LSB = BLK_CODE_W;

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) begin
                base_o[c] <= '0;
                disc_o[c] <= 1'b0;
                if (c == 0) begin
                    blk_o[c] <= '1;
                    opt_o[c] <= BOOT_OPT;
                    pin_o[c] <= boot_d0 ? PIN_CS_WIDE : PIN_CS_NARROW;
                end else begin
                    blk_o[c] <= '0;
                    opt_o[c] <= '0;
                    pin_o[c] <= PIN_CS_WIDE;
                end
            end
        end else if (cfg_we && (int'(cfg_ch) < NUM_CH)) begin
            case (cfg_reg)
                2'd0: begin
                    base_o[cfg_ch] <= cfg_wdata[BASE_LSB +: BASE_W];
                    blk_o[cfg_ch]  <= cfg_wdata[BLK_CODE_W-1:0];
                end
                2'd1: opt_o[cfg_ch] <= opt_t'(cfg_wdata[OPT_W-1:0]);
                2'd2: begin
                    pin_o[cfg_ch]  <= pin_mode_e'(cfg_wdata[1:0]);
                    disc_o[cfg_ch] <= cfg_wdata[2];
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 1; g < NUM_CH; g++) begin : g_rst_chk
        AST_RESET_LANES_OFF: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> opt_o[g].lanes == 2'b00)
            else $error("non-boot channel enabled out of reset"); // R4
    end

endmodule

// File: rtl/csd_match.sv
module csd_match
    import csd_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int MIN_BLK_LG = 11,
    parameter int BASE_W     = ADDR_W - MIN_BLK_LG
) (
    input  logic [BASE_W-1:0]     base,
    input  logic [BLK_CODE_W-1:0] blk,
    input  opt_t                  opt,
    input  pin_mode_e             pin,
    input  logic [BASE_W-1:0]     addr_hi,
    input  logic                  bus_as,
    input  logic                  bus_ds,
    input  logic [1:0]            bus_space,
    input  logic                  bus_read,
    input  logic [1:0]            bus_lanes,
    input  logic [2:0]            bus_ipl,
    input  logic                  bus_internal,
    output logic                  hit_d
);

    logic addr_ok, attr_ok, strobe;

    always_comb begin
        addr_ok = 1'b1;
        for (int i = 0; i < BASE_W; i++) begin
            if ((i >= int'(blk)) && (addr_hi[i] != base[i])) addr_ok = 1'b0;
        end
    end

    assign attr_ok = (|(opt.lanes & bus_lanes))
                   && dir_ok(opt.dir, bus_read)
                   && space_ok(opt.space, bus_space)
                   && level_ok(opt.space, opt.level, bus_ipl);

    assign strobe = opt.on_ds ? bus_ds : bus_as;

    assign hit_d = addr_ok && attr_ok && strobe && !bus_internal && pin[1];

endmodule

// File: rtl/csd_term.sv
module csd_term
    import csd_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hit_q,
    input  logic [TERM_W-1:0] term_i [NUM_CH],
    input  logic [NUM_CH-1:0] wide_i,
    output logic              int_ack,
    output logic              ack_wide
);

    logic [TERM_W-1:0] waited [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || !hit_q[g])        waited[g] <= '0;
            else if (waited[g] != '1)    waited[g] <= waited[g] + 1'b1;
        end
    end

    always_comb begin
        logic found;
        found    = 1'b0;
        int_ack  = 1'b0;
        ack_wide = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (!found && hit_q[c]) begin
                found = 1'b1;
                if (term_i[c] == TERM_FAST)
                    int_ack = 1'b1;
                else if (term_i[c] <= TERM_MAX_WAIT && waited[c] > term_i[c])
                    int_ack = 1'b1;
                ack_wide = int_ack && wide_i[c];
            end
        end
    end

    AST_ACK_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        int_ack |-> (hit_q != '0))
        else $error("acknowledge without a select"); // R8

    AST_WIDE_ONLY_ACK: assert property (@(posedge clk) disable iff (rst)
        ack_wide |-> int_ack)
        else $error("width reported without acknowledge"); // R8

endmodule

// File: rtl/chipsel_decoder.sv
module chipsel_decoder
    import csd_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int ADDR_W     = 24,
    parameter int MIN_BLK_LG = 11,
    parameter int CFG_W      = 16,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BASE_W    = ADDR_W - MIN_BLK_LG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_d0,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_reg,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              bus_as,
    input  logic              bus_ds,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_space,
    input  logic              bus_read,
    input  logic [1:0]        bus_lanes,
    input  logic [2:0]        bus_ipl,
    input  logic              bus_internal,
    input  logic [NUM_CH-1:0] alt_in,
    output logic [NUM_CH-1:0] pin_out,
    output logic              int_ack,
    output logic              ack_wide
);

    logic [BASE_W-1:0]     base [NUM_CH];
    logic [BLK_CODE_W-1:0] blk  [NUM_CH];
    opt_t                  opt  [NUM_CH];
    pin_mode_e             pin  [NUM_CH];
    logic [NUM_CH-1:0]     disc;
    logic [NUM_CH-1:0]     hit_d, hit_q, wide;
    logic [TERM_W-1:0]     term [NUM_CH];

    logic unused_addr_low;
    assign unused_addr_low = ^bus_addr[MIN_BLK_LG-1:0];

    csd_cfg_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W), .BASE_W(BASE_W), .CFG_W(CFG_W)) u_cfg (
        .clk, .rst, .boot_d0, .cfg_we, .cfg_ch, .cfg_reg, .cfg_wdata,
        .base_o(base), .blk_o(blk), .opt_o(opt), .pin_o(pin), .disc_o(disc)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        csd_match #(.ADDR_W(ADDR_W), .MIN_BLK_LG(MIN_BLK_LG), .BASE_W(BASE_W)) u_match (
            .base(base[g]), .blk(blk[g]), .opt(opt[g]), .pin(pin[g]),
            .addr_hi(bus_addr[ADDR_W-1:MIN_BLK_LG]),
            .bus_as, .bus_ds, .bus_space, .bus_read, .bus_lanes, .bus_ipl,
            .bus_internal, .hit_d(hit_d[g])
        );

        assign term[g] = opt[g].term;
        assign wide[g] = (pin[g] == PIN_CS_WIDE);

        always_comb begin
            case (pin[g])
                PIN_DISCRETE:  pin_out[g] = disc[g];
                PIN_ALTERNATE: pin_out[g] = alt_in[g];
                default:       pin_out[g] = !hit_q[g];
            endcase
        end

        AST_NON_CS_QUIET: assert property (@(posedge clk) disable iff (rst)
            !pin[g][1] |=> !hit_q[g])
            else $error("select on a pin not in select mode"); // R9
    end

    always_ff @(posedge clk) begin
        if (rst) hit_q <= '0;
        else     hit_q <= hit_d;
    end

    csd_term #(.NUM_CH(NUM_CH)) u_term (
        .clk, .rst, .hit_q, .term_i(term), .wide_i(wide), .int_ack, .ack_wide
    );

    AST_INTERNAL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        bus_internal |=> hit_q == '0)
        else $error("select during internal access"); // R5

    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        (!bus_as && !bus_ds) |=> hit_q == '0)
        else $error("select with no strobe"); // R6

endmodule

// File: tb/sim_chipsel_decoder.sv
module sim_chipsel_decoder;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_d0 = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [1:0]  cfg_reg = '0;
    logic [15:0] cfg_wdata = '0;
    logic        bus_as = 1'b0, bus_ds = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [1:0]  bus_space = 2'b01;
    logic        bus_read = 1'b1;
    logic [1:0]  bus_lanes = 2'b11;
    logic [2:0]  bus_ipl = '0;
    logic        bus_internal = 1'b0;
    logic [N-1:0] alt_in = '0;
    logic [N-1:0] pin_out;
    logic        int_ack, ack_wide;

    always #10 clk = ~clk;

    chipsel_decoder u0 (
        .clk, .rst, .boot_d0, .cfg_we, .cfg_ch, .cfg_reg, .cfg_wdata,
        .bus_as, .bus_ds, .bus_addr, .bus_space, .bus_read, .bus_lanes,
        .bus_ipl, .bus_internal, .alt_in, .pin_out, .int_ack, .ack_wide
    );

    int    n_cmp = 0, n_bad = 0, cycles = 0;
    string phase = "R10 reset";

    // ---------------- reference model ----------------
    logic [23:0] m_base [N];
    int          m_blk  [N];
    logic [15:0] m_opt  [N];
    logic [15:0] m_pin  [N];
    bit          m_hit  [N];
    int          m_run  [N];

    function automatic bit m_match(int c);
        logic [15:0] o = m_opt[c];
        int sh = 11 + m_blk[c];
        bit ok;
        ok = ((bus_addr >> sh) == (m_base[c] >> sh));
        ok = ok && ((o[1:0] & bus_lanes) != 2'b00);
        ok = ok && (bus_read ? o[2] : o[3]);
        case (o[10:9])
            2'b00: ok = ok && bus_space == 2'b00 && (o[13:11] == 0 || o[13:11] == bus_ipl);
            2'b01: ok = ok && bus_space == 2'b01;
            2'b10: ok = ok && bus_space == 2'b10;
            default: ok = ok && (bus_space == 2'b01 || bus_space == 2'b10);
        endcase
        ok = ok && (o[4] ? bus_ds : bus_as);
        ok = ok && !bus_internal && (m_pin[c][1:0] >= 2);
        return ok;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < N; c++) begin
                m_base[c] = '0; m_hit[c] = 0; m_run[c] = 0;
                m_blk[c]  = (c == 0) ? 7 : 0;
                m_opt[c]  = (c == 0) ? 16'h07AF : 16'h0000;
                m_pin[c]  = (c == 0) ? (boot_d0 ? 16'd3 : 16'd2) : 16'd3;
            end
        end else begin
            for (int c = 0; c < N; c++) begin
                m_run[c] = m_hit[c] ? ((m_run[c] < 15) ? m_run[c] + 1 : 15) : 0;
                m_hit[c] = m_match(c);
            end
            if (cfg_we) begin
                if (cfg_reg == 0) begin
                    m_base[cfg_ch] = {cfg_wdata[15:3], 11'd0};
                    m_blk[cfg_ch]  = int'(cfg_wdata[2:0]);
                end else if (cfg_reg == 1) m_opt[cfg_ch] = cfg_wdata;
                else if (cfg_reg == 2)     m_pin[cfg_ch] = cfg_wdata;
            end
        end
    end

    task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            logic [N-1:0] e_pin;
            bit e_ack, e_wide, found;
            int t;
            e_ack = 0; e_wide = 0; found = 0;
            for (int c = 0; c < N; c++) begin
                case (m_pin[c][1:0])
                    2'd0: e_pin[c] = m_pin[c][2];
                    2'd1: e_pin[c] = alt_in[c];
                    default: e_pin[c] = !m_hit[c];
                endcase
                if (!found && m_hit[c]) begin
                    found = 1;
                    t = int'(m_opt[c][8:5]);
                    e_ack = (t == 14) || (t <= 13 && m_run[c] > t);
                    e_wide = e_ack && (m_pin[c][1:0] == 2'd3);
                end
            end
            check("pins", 8'(pin_out), 8'(e_pin));
            check("ack", 8'(int_ack), 8'(e_ack));
            check("width", 8'(ack_wide), 8'(e_wide));
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(); @(negedge clk); #1; endtask

    task automatic do_reset(input logic d0);
        step(); rst = 1'b1; boot_d0 = d0;
        repeat (3) step();
        rst = 1'b0; boot_d0 = ~d0;
    endtask

    task automatic wr(input int ch, input int rg, input logic [15:0] d);
        step(); cfg_we = 1; cfg_ch = 2'(ch); cfg_reg = 2'(rg); cfg_wdata = d;
        step(); cfg_we = 0;
    endtask

    function automatic logic [15:0] mk_opt(int ln, int dr, int ds, int tm, int sp, int lv);
        return {2'b00, 3'(lv), 2'(sp), 4'(tm), 1'(ds), 2'(dr), 2'(ln)};
    endfunction

    function automatic logic [15:0] mk_base(logic [23:0] a, int k);
        return {a[23:11], 3'(k)};
    endfunction

    task automatic cyc(input logic [23:0] a, input int sp, input bit rd, input int ln,
                       input int lv, input bit use_ds, input bit ih, input int n);
        step();
        bus_addr = a; bus_space = 2'(sp); bus_read = rd; bus_lanes = 2'(ln);
        bus_ipl = 3'(lv); bus_internal = ih; bus_as = 1;
        step(); bus_ds = use_ds;
        repeat (n) step();
        bus_as = 0; bus_ds = 0; bus_internal = 0;
        repeat (3) step();
    endtask

    initial begin
        do_reset(1'b1);
        phase = "R10 reset state"; repeat (3) step();
        phase = "R10 R7 boot 13 waits wide"; cyc(24'h001000, 1, 1, 3, 0, 0, 0, 18);
        phase = "R10 boot supervisor write"; cyc(24'h03F000, 2, 0, 1, 0, 0, 0, 6);

        wr(1, 0, mk_base(24'h040000, 0));
        wr(1, 1, mk_opt(3, 1, 0, 2, 1, 0));
        wr(1, 2, 16'd2);
        phase = "R1 inside 2K window"; cyc(24'h0407FF, 1, 1, 3, 0, 0, 0, 6);
        phase = "R1 just past window"; cyc(24'h040800, 1, 1, 3, 0, 0, 0, 4);
        phase = "R3 write to read-only"; cyc(24'h040010, 1, 0, 3, 0, 0, 0, 4);
        phase = "R2 supervisor on user-only"; cyc(24'h040010, 2, 1, 3, 0, 0, 0, 4);
        wr(1, 0, mk_base(24'h040000, 2));
        phase = "R1 8K window top"; cyc(24'h041FFF, 1, 1, 3, 0, 0, 0, 6);

        wr(2, 0, mk_base(24'h080000, 0));
        wr(2, 1, mk_opt(1, 3, 1, 14, 0, 5));
        wr(2, 2, 16'd3);
        phase = "R2 R6 level match data strobe"; cyc(24'h080010, 0, 1, 1, 5, 1, 0, 5);
        phase = "R2 level mismatch"; cyc(24'h080010, 0, 1, 1, 3, 1, 0, 4);
        phase = "R4 upper lane only"; cyc(24'h080010, 0, 1, 2, 5, 1, 0, 4);
        phase = "R6 address strobe only"; cyc(24'h080010, 0, 1, 1, 5, 0, 0, 4);
        phase = "R2 user cycle on cpu channel"; cyc(24'h080010, 1, 1, 1, 5, 1, 0, 4);
        wr(2, 1, mk_opt(1, 3, 1, 14, 0, 0));
        phase = "R2 any level"; cyc(24'h080010, 0, 1, 1, 2, 1, 0, 4);

        phase = "R5 internal target boot"; cyc(24'h000200, 1, 1, 3, 0, 0, 1, 5);
        phase = "R5 internal target ch1"; cyc(24'h040100, 1, 1, 3, 0, 0, 1, 5);

        wr(1, 2, 16'd3);
        wr(3, 0, mk_base(24'h040000, 3));
        wr(3, 1, mk_opt(3, 3, 0, 14, 3, 0));
        wr(3, 2, 16'd2);
        phase = "R8 overlap lowest decides"; cyc(24'h040100, 1, 1, 3, 0, 0, 0, 6);
        phase = "R8 R7 upper channel alone fast"; cyc(24'h043000, 1, 1, 3, 0, 0, 0, 4);
        wr(1, 1, mk_opt(3, 1, 0, 15, 1, 0));
        phase = "R7 R8 external termination"; cyc(24'h040100, 1, 1, 3, 0, 0, 0, 6);
        wr(1, 1, mk_opt(3, 1, 0, 0, 1, 0));
        phase = "R7 zero waits"; cyc(24'h040100, 1, 1, 3, 0, 0, 0, 4);

        wr(2, 2, 16'h0004);
        phase = "R9 discrete high"; repeat (3) step();
        phase = "R9 no select on discrete pin"; cyc(24'h080010, 0, 1, 1, 2, 1, 0, 4);
        wr(2, 2, 16'h0000);
        phase = "R9 discrete low"; repeat (3) step();
        wr(2, 2, 16'h0001);
        phase = "R9 alternate"; alt_in = 4'b0100; step(); step();
        alt_in = 4'b0000; step(); step();
        alt_in = 4'b0100; step(); step();

        do_reset(1'b0);
        phase = "R10 narrow boot"; cyc(24'h002000, 1, 1, 3, 0, 0, 0, 16);
        phase = "R4 channels off after reset"; cyc(24'h040100, 1, 1, 3, 0, 0, 0, 4);
        cyc(24'h080010, 0, 1, 1, 5, 1, 0, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule